// File: doc/BRIEF.md
# Predicated Commit Stage with Deferred Fault Tokens

This block is the final stage of a statically scheduled pipeline. Completed operations arrive on a fixed number of parallel slots, already computed and carrying their fault status. Each operation names a qualifying predicate, and the stage either commits its effect or drops it. Two state arrays live here. The first is a one-bit predicate file. The second is a general register file in which every entry carries an extra "poison" token bit that marks a deferred fault.

Compares write a predicate pair: the target gets the outcome and its partner gets the inverse. Both arms of an if-converted branch can travel together, because only the arm with a true predicate lands. A speculative load that faults marks its destination as poisoned and does not trap. Poison spreads through dependent arithmetic. A check operation turns a poisoned register into a one-cycle recovery request. A non-speculative load that faults raises an immediate exception. Two registered read ports, one for registers and one for predicates, make the state visible.

Operation codes on `slot_op` are 0 idle, 1 arithmetic, 2 load, 3 speculative load, 4 compare and 5 check. Any other code is idle. Slot s takes bits [3s+2:3s] of `slot_op`, and its 6-bit fields take [6s+5:6s].

Top module: `pred_commit`

## Requirements
- R1: While `rst` is high (synchronous, active high), every register is cleared to data 0 with its token clear, every predicate except entry 0 is cleared to 0, and `rcv_req` and `exc_req` are held low.
- R2: An enabled compare (code 4) writes `slot_cmp` to predicate `slot_dst` and its inverse to predicate `slot_dst2`. Both read ports are registered, so a read presented in the cycle after the write edge returns the new value one edge later.
- R3: When the qualifying predicate named by `slot_qp` reads false, the operation has no effect: no register write, no predicate write, no recovery request and no exception.
- R4: When two slots in the same cycle target the same register and only one slot's predicate is true, that slot's value is committed whatever its slot index.
- R5: When two or more enabled slots write the same register in one cycle, the highest slot index wins.
- R6: Predicate 0 always reads true, and writes to it are ignored.
- R7: A compare whose own qualifying predicate is false leaves both predicate targets unchanged.
- R8: A speculative load (code 3) with `slot_flt` set writes data 0 with the token set and raises no exception. Without a fault, it writes its data with the token clear.
- R9: An arithmetic operation (code 1) writes its destination token as the OR of the tokens of `slot_srca` and `slot_srcb`. Sources are read as they stand before any commit in the same cycle.
- R10: An enabled check (code 5) on a register `slot_srca` with its token set raises `rcv_req` for exactly one cycle, one edge later, with `rcv_slot` and `rcv_reg` set to the slot and the register. If several checks hit in one cycle, the lowest slot is reported.
- R11: An enabled load (code 2) with `slot_flt` set raises `exc_req` for one cycle, one edge later, with `exc_slot` naming the lowest such slot. Its destination register, data and token, stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | NSLOT | Per-slot operation valid |
| slot_op | input | 3*NSLOT | Per-slot operation code |
| slot_qp | input | AW*NSLOT | Qualifying predicate index |
| slot_dst | input | AW*NSLOT | Destination register, or first predicate target for a compare |
| slot_dst2 | input | AW*NSLOT | Second predicate target for a compare |
| slot_srca | input | AW*NSLOT | First source register (the register tested by a check) |
| slot_srcb | input | AW*NSLOT | Second source register |
| slot_data | input | DW*NSLOT | Result data |
| slot_cmp | input | NSLOT | Compare outcome |
| slot_flt | input | NSLOT | Load fault status |
| rd_reg | input | AW | Register read address |
| rd_data | output | DW | Registered register data |
| rd_tok | output | 1 | Registered register token |
| rd_pred | input | AW | Predicate read address |
| rd_pval | output | 1 | Registered predicate value |
| rcv_req | output | 1 | Recovery request pulse |
| rcv_slot | output | SW | Slot of the check that hit |
| rcv_reg | output | AW | Register that was checked |
| exc_req | output | 1 | Immediate load exception pulse |
| exc_slot | output | SW | Slot of the faulting load |

## Verification
Every result appears one edge after the edge that samples the slot inputs. A commit at edge k shows on the read ports at edge k+1 if the address is presented after edge k. The recovery and exception pulses are registered at the same edge as the commit they come from. The bench drives each cycle's inputs 1 ns after an edge. From its model state before the next edge, it computes what that edge must produce. It then compares every output 1 ns after the edge, and so checks the one-cycle latency on every clock.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ALU = 3'd1,
    OP_LD  = 3'd2,
    OP_LDS = 3'd3,
    OP_CMP = 3'd4,
    OP_CHK = 3'd5
  } op_e;

  typedef struct packed {
    logic rwe;   // register write enable
    logic rtok;  // token value for the register write
    logic pwe;   // predicate pair write enable
    logic chk;   // check found a poisoned source
    logic exc;   // non-speculative load fault
  } slot_act_t;
endpackage

// File: rtl/pcw_slot_dec.sv
module pcw_slot_dec
  import pcw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          vld,
  input  logic [2:0]    op,
  input  logic          qv,
  input  logic          ta,
  input  logic          tb,
  input  logic          flt,
  input  logic [DW-1:0] din,
  output slot_act_t     act,
  output logic [DW-1:0] dout
);
  logic en;

  always_comb begin
    en   = vld & qv;
    act  = '0;
    dout = din;
    case (op_e'(op))
      OP_ALU: begin
        act.rwe  = en;
        act.rtok = ta | tb;
      end
      OP_LD: begin
        if (flt) act.exc = en;
        else     act.rwe = en;
      end
      OP_LDS: begin
        act.rwe  = en;
        act.rtok = flt;
        if (flt) dout = '0;
      end
      OP_CMP: act.pwe = en;
      OP_CHK: act.chk = en & ta;
      default: act = '0;
    endcase
  end
endmodule

// File: rtl/pcw_pred_file.sv
module pcw_pred_file #(
  parameter int NP = 64,
  parameter int AW = 6,
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we   [NS],
  input  logic [AW-1:0] wa   [NS],
  input  logic [AW-1:0] wb   [NS],
  input  logic          wv   [NS],
  input  logic [AW-1:0] qa   [NS],
  output logic          qv   [NS],
  input  logic [AW-1:0] rd_a,
  output logic          rd_v
);
  logic [NP-1:0] pr;

  // entry 0 is tied true on every read path
  always_comb begin
    for (int s = 0; s < NS; s++) qv[s] = (qa[s] == '0) ? 1'b1 : pr[qa[s]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pr   <= '0;
      rd_v <= 1'b0;
    end else begin
      rd_v <= (rd_a == '0) ? 1'b1 : pr[rd_a];
      for (int s = 0; s < NS; s++) begin
        if (we[s]) begin
          if (wa[s] != '0) pr[wa[s]] <= wv[s];
          if (wb[s] != '0) pr[wb[s]] <= ~wv[s];
        end
      end
    end
  end
endmodule

// File: rtl/pcw_reg_file.sv
module pcw_reg_file #(
  parameter int NR = 64,
  parameter int DW = 32,
  parameter int AW = 6,
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we    [NS],
  input  logic [AW-1:0] wa    [NS],
  input  logic [DW-1:0] wd    [NS],
  input  logic          wt    [NS],
  input  logic [AW-1:0] sa    [NS],
  input  logic [AW-1:0] sb    [NS],
  output logic          sa_t  [NS],
  output logic          sb_t  [NS],
  input  logic [AW-1:0] rd_a,
  output logic [DW-1:0] rd_d,
  output logic          rd_t
);
  logic [DW-1:0] mem [NR];
  logic [NR-1:0] tok;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      sa_t[s] = tok[sa[s]];
      sb_t[s] = tok[sb[s]];
    end
  end

  // ascending slot order: the last matching assignment, the highest slot, lands
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NR; r++) mem[r] <= '0;
      tok  <= '0;
      rd_d <= '0;
      rd_t <= 1'b0;
    end else begin
      rd_d <= mem[rd_a];
      rd_t <= tok[rd_a];
      for (int s = 0; s < NS; s++) begin
        if (we[s]) begin
          mem[wa[s]] <= wd[s];
          tok[wa[s]] <= wt[s];
        end
      end
    end
  end
endmodule

// File: rtl/pred_commit.sv
module pred_commit
  import pcw_pkg::*;
#(
  parameter int NSLOT = 2,
  parameter int NREG  = 64,
  parameter int NPRED = 64,
  parameter int DW    = 32,
  parameter int AW    = 6,
  parameter int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSLOT-1:0]    slot_vld,
  input  logic [3*NSLOT-1:0]  slot_op,
  input  logic [AW*NSLOT-1:0] slot_qp,
  input  logic [AW*NSLOT-1:0] slot_dst,
  input  logic [AW*NSLOT-1:0] slot_dst2,
  input  logic [AW*NSLOT-1:0] slot_srca,
  input  logic [AW*NSLOT-1:0] slot_srcb,
  input  logic [DW*NSLOT-1:0] slot_data,
  input  logic [NSLOT-1:0]    slot_cmp,
  input  logic [NSLOT-1:0]    slot_flt,
  input  logic [AW-1:0]       rd_reg,
  output logic [DW-1:0]       rd_data,
  output logic                rd_tok,
  input  logic [AW-1:0]       rd_pred,
  output logic                rd_pval,
  output logic                rcv_req,
  output logic [SW-1:0]       rcv_slot,
  output logic [AW-1:0]       rcv_reg,
  output logic                exc_req,
  output logic [SW-1:0]       exc_slot
);
  logic [AW-1:0] qa [NSLOT];
  logic          qv [NSLOT];
  logic [AW-1:0] da [NSLOT];
  logic [AW-1:0] db [NSLOT];
  logic [AW-1:0] sa [NSLOT];
  logic [AW-1:0] sb [NSLOT];
  logic          ta [NSLOT];
  logic          tb [NSLOT];
  logic [DW-1:0] wd [NSLOT];
  logic          rwe [NSLOT];
  logic          rtk [NSLOT];
  logic          pwe [NSLOT];
  logic          pwv [NSLOT];
  slot_act_t     act [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign qa[s]  = slot_qp[s*AW +: AW];
    assign da[s]  = slot_dst[s*AW +: AW];
    assign db[s]  = slot_dst2[s*AW +: AW];
    assign sa[s]  = slot_srca[s*AW +: AW];
    assign sb[s]  = slot_srcb[s*AW +: AW];
    assign rwe[s] = act[s].rwe;
    assign rtk[s] = act[s].rtok;
    assign pwe[s] = act[s].pwe;
    assign pwv[s] = slot_cmp[s];

    pcw_slot_dec #(.DW(DW)) u_dec (
      .vld  (slot_vld[s]),
      .op   (slot_op[s*3 +: 3]),
      .qv   (qv[s]),
      .ta   (ta[s]),
      .tb   (tb[s]),
      .flt  (slot_flt[s]),
      .din  (slot_data[s*DW +: DW]),
      .act  (act[s]),
      .dout (wd[s])
    );
  end

  pcw_pred_file #(.NP(NPRED), .AW(AW), .NS(NSLOT)) u_pred (
    .clk  (clk),
    .rst  (rst),
    .we   (pwe),
    .wa   (da),
    .wb   (db),
    .wv   (pwv),
    .qa   (qa),
    .qv   (qv),
    .rd_a (rd_pred),
    .rd_v (rd_pval)
  );

  pcw_reg_file #(.NR(NREG), .DW(DW), .AW(AW), .NS(NSLOT)) u_regs (
    .clk  (clk),
    .rst  (rst),
    .we   (rwe),
    .wa   (da),
    .wd   (wd),
    .wt   (rtk),
    .sa   (sa),
    .sb   (sb),
    .sa_t (ta),
    .sb_t (tb),
    .rd_a (rd_reg),
    .rd_d (rd_data),
    .rd_t (rd_tok)
  );

  // event selection: walk downwards so the lowest hitting slot is kept
  logic          c_hit, e_hit;
  logic [SW-1:0] c_slot, e_slot;
  logic [AW-1:0] c_reg;

  always_comb begin
    c_hit  = 1'b0;
    c_slot = '0;
    c_reg  = '0;
    e_hit  = 1'b0;
    e_slot = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (act[s].chk) begin
        c_hit  = 1'b1;
        c_slot = SW'(s);
        c_reg  = sa[s];
      end
      if (act[s].exc) begin
        e_hit  = 1'b1;
        e_slot = SW'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rcv_req  <= 1'b0;
      rcv_slot <= '0;
      rcv_reg  <= '0;
      exc_req  <= 1'b0;
      exc_slot <= '0;
    end else begin
      rcv_req  <= c_hit;
      rcv_slot <= c_slot;
      rcv_reg  <= c_reg;
      exc_req  <= e_hit;
      exc_slot <= e_slot;
    end
  end
endmodule

// File: rtl/pcw_commit_chk.sv
module pcw_commit_chk #(
  parameter int NSLOT = 2,
  parameter int AW    = 6,
  parameter int SW    = 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NSLOT-1:0]   slot_vld,
  input logic [3*NSLOT-1:0] slot_op,
  input logic [NSLOT-1:0]   slot_flt,
  input logic [AW-1:0]      rd_pred,
  input logic               rd_pval,
  input logic               rcv_req,
  input logic [SW-1:0]      rcv_slot,
  input logic               exc_req,
  input logic [SW-1:0]      exc_slot
);
  logic [NSLOT-1:0] chk_seen, ld_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_seen <= '0;
      ld_seen  <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        chk_seen[s] <= slot_vld[s] && (slot_op[s*3 +: 3] == 3'd5);
        ld_seen[s]  <= slot_vld[s] && (slot_op[s*3 +: 3] == 3'd2) && slot_flt[s];
      end
    end
  end

  // R10
  rcv_from_check_chk: assert property (@(posedge clk) disable iff (rst)
    rcv_req |-> chk_seen[rcv_slot]);

  // R11
  exc_from_load_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> ld_seen[exc_slot]);

  // R6
  pred_zero_true_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(rd_pred) == '0)) |-> rd_pval);

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rcv_req && !exc_req));
endmodule

bind pred_commit pcw_commit_chk #(.NSLOT(NSLOT), .AW(AW), .SW(SW)) u_pcw_chk (.*);

// File: tb/test_pred_commit.sv
module test_pred_commit;
  localparam int NS = 2;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int N  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0]    slot_vld = '0;
  logic [3*NS-1:0]  slot_op = '0;
  logic [AW*NS-1:0] slot_qp = '0, slot_dst = '0, slot_dst2 = '0, slot_srca = '0, slot_srcb = '0;
  logic [DW*NS-1:0] slot_data = '0;
  logic [NS-1:0]    slot_cmp = '0, slot_flt = '0;
  logic [AW-1:0]    rd_reg = '0, rd_pred = '0;
  logic [DW-1:0]    rd_data;
  logic             rd_tok, rd_pval, rcv_req, exc_req;
  logic [0:0]       rcv_slot, exc_slot;
  logic [AW-1:0]    rcv_reg;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] mdata [N];
  bit mtok [N];
  bit mpred [N];

  always #5 clk = ~clk;

  pred_commit i_pred_commit (.*);

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic set_slot(input int s, input int op, input int qp, input int dst, input int dst2,
                          input int sa, input int sb, input logic [DW-1:0] d, input bit c, input bit f);
    slot_vld[s] = 1'b1;
    slot_op[s*3 +: 3]    = 3'(op);
    slot_qp[s*AW +: AW]  = AW'(qp);
    slot_dst[s*AW +: AW] = AW'(dst);
    slot_dst2[s*AW +: AW] = AW'(dst2);
    slot_srca[s*AW +: AW] = AW'(sa);
    slot_srcb[s*AW +: AW] = AW'(sb);
    slot_data[s*DW +: DW] = d;
    slot_cmp[s] = c;
    slot_flt[s] = f;
  endtask

  // one clock: model predicts this edge from pre-edge state, then compares
  task automatic tick(input string tag);
    logic [DW-1:0] e_d;
    bit e_t, e_p, e_r, e_x;
    int e_rs, e_rr, e_xs;
    bit we [NS];
    bit wt [NS];
    bit pw [NS];
    logic [DW-1:0] wd [NS];
    e_d = mdata[rd_reg]; e_t = mtok[rd_reg];
    e_p = (rd_pred == 0) ? 1'b1 : mpred[rd_pred];
    e_r = 0; e_x = 0; e_rs = 0; e_rr = 0; e_xs = 0;
    for (int s = NS - 1; s >= 0; s--) begin
      int o, q, sa, sb;
      bit en;
      o  = int'(slot_op[s*3 +: 3]);
      q  = int'(slot_qp[s*AW +: AW]);
      sa = int'(slot_srca[s*AW +: AW]);
      sb = int'(slot_srcb[s*AW +: AW]);
      en = slot_vld[s] && ((q == 0) ? 1'b1 : mpred[q]);
      we[s] = 0; wt[s] = 0; pw[s] = 0; wd[s] = slot_data[s*DW +: DW];
      case (o)
        1: begin we[s] = en; wt[s] = mtok[sa] | mtok[sb]; end
        2: if (slot_flt[s]) begin if (en) begin e_x = 1; e_xs = s; end end else we[s] = en;
        3: begin we[s] = en; wt[s] = slot_flt[s]; if (slot_flt[s]) wd[s] = '0; end
        4: pw[s] = en;
        5: if (en && mtok[sa]) begin e_r = 1; e_rs = s; e_rr = sa; end
        default: ;
      endcase
    end
    for (int s = 0; s < NS; s++) begin
      int d1, d2;
      d1 = int'(slot_dst[s*AW +: AW]);
      d2 = int'(slot_dst2[s*AW +: AW]);
      if (we[s]) begin mdata[d1] = wd[s]; mtok[d1] = wt[s]; end
      if (pw[s]) begin
        if (d1 != 0) mpred[d1] = slot_cmp[s];
        if (d2 != 0) mpred[d2] = ~slot_cmp[s];
      end
    end
    @(posedge clk); #1;
    check(tag, "rd_data", 64'(rd_data), 64'(e_d));
    check(tag, "rd_tok", 64'(rd_tok), 64'(e_t));
    check(tag, "rd_pval", 64'(rd_pval), 64'(e_p));
    check(tag, "recovery", {rcv_req, rcv_req ? 32'(rcv_slot) : 32'd0, rcv_req ? 16'(rcv_reg) : 16'd0},
          {e_r, 32'(e_rs), 16'(e_rr)});
    check(tag, "exception", {exc_req, exc_req ? 32'(exc_slot) : 32'd0}, {e_x, 32'(e_xs)});
    slot_vld = '0;
  endtask

  task automatic rd(input int r, input int p, input string tag);
    rd_reg = AW'(r); rd_pred = AW'(p);
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mdata[i] = '0; mtok[i] = 0; mpred[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    for (int i = 0; i < 4; i++) rd(i + 3, i, "R1");
    // R2 compare pair
    set_slot(0, 4, 0, 5, 6, 0, 0, 0, 1, 0); tick("R2");
    rd(0, 5, "R2"); rd(0, 6, "R2");
    // R7 compare with false qualifier (p6 false), would have set p8
    set_slot(1, 4, 6, 7, 8, 0, 0, 0, 0, 0); tick("R7");
    rd(0, 7, "R7"); rd(0, 8, "R7");
    // R6 write to predicate 0 ignored, partner still written
    set_slot(0, 4, 0, 0, 9, 0, 0, 0, 0, 0); tick("R6");
    rd(0, 0, "R6"); rd(0, 9, "R6");
    // R4 both arms: true arm in slot 0, false arm in slot 1
    set_slot(0, 1, 5, 3, 0, 1, 2, 32'h11, 0, 0);
    set_slot(1, 1, 6, 3, 0, 1, 2, 32'h22, 0, 0); tick("R4");
    rd(3, 0, "R4");
    // R4 both arms: false arm in slot 0, true arm in slot 1
    set_slot(0, 1, 6, 3, 0, 1, 2, 32'h33, 0, 0);
    set_slot(1, 1, 5, 3, 0, 1, 2, 32'h44, 0, 0); tick("R4");
    rd(3, 0, "R4");
    // R5 both enabled, highest slot wins
    set_slot(0, 1, 0, 4, 0, 1, 2, 32'h55, 0, 0);
    set_slot(1, 1, 0, 4, 0, 1, 2, 32'h66, 0, 0); tick("R5");
    rd(4, 0, "R5");
    // R8 faulting speculative load
    set_slot(0, 3, 0, 10, 0, 0, 0, 32'h99, 0, 1); tick("R8");
    rd(10, 0, "R8");
    set_slot(1, 3, 0, 13, 0, 0, 0, 32'h77, 0, 0); tick("R8");
    rd(13, 0, "R8");
    // R9 token propagation and clean sources
    set_slot(0, 1, 0, 11, 0, 4, 10, 32'h5a, 0, 0);
    set_slot(1, 1, 0, 12, 0, 3, 4, 32'ha5, 0, 0); tick("R9");
    rd(11, 0, "R9"); rd(12, 0, "R9");
    // R10 check hit on slot 1, then quiet, then clean register
    set_slot(1, 5, 0, 0, 0, 11, 0, 0, 0, 0); tick("R10");
    rd(0, 0, "R10");
    set_slot(0, 5, 0, 0, 0, 12, 0, 0, 0, 0); tick("R10");
    set_slot(0, 5, 0, 0, 0, 10, 0, 0, 0, 0);
    set_slot(1, 5, 0, 0, 0, 11, 0, 0, 0, 0); tick("R10");
    // R3 check under false qualifier is suppressed
    set_slot(0, 5, 6, 0, 0, 11, 0, 0, 0, 0); tick("R3");
    // R11 faulting load: exception, destination unchanged
    set_slot(1, 2, 0, 3, 0, 0, 0, 32'hdead, 0, 1); tick("R11");
    rd(3, 0, "R11");
    set_slot(0, 2, 6, 3, 0, 0, 0, 32'hbeef, 0, 1); tick("R3");
    // mixed traffic on a small address window
    for (int i = 0; i < 400; i++) begin
      for (int s = 0; s < NS; s++)
        if ($urandom_range(0, 3) != 0)
          set_slot(s, $urandom_range(0, 5), $urandom_range(0, 7), $urandom_range(0, 7),
                   $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                   $urandom, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      rd_reg = AW'($urandom_range(0, 7)); rd_pred = AW'($urandom_range(0, 7));
      tick("R3/R5 mixed");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule